// File: doc/BRIEF.md
# Chip-Select Address Range Decoder

This block works out which of a small set of memory chip-select rows owns a given physical address. Each row has its own programmed 32-bit bounds word. The word holds a start page and an end page, both counted in 16 MB units. A row covers every address from its start page up to and including the last byte of its end page. A row whose start and end are equal is treated as empty and is never selected.

For the incoming address, the decoder drives a one-hot row match, the binary index of that row and a flag for addresses that fall in no populated row. When rows overlap, the lowest-numbered row is reported. The address path is purely combinational, so a lookup costs no cycles.

The same write port loads a configuration word. The block decodes the memory generation from that word and brings out a separate flag that marks registered modules. All registers are written through one select-addressed port, and a write takes effect on the next clock edge.

Top module: `cs_range_decoder`

## Requirements
- R1: After reset every bounds word and the configuration word are zero, so every address is out of range, `mem_type` is 0 and `registered` is 0.
- R2: A write with `wr_sel` equal to 0..3 loads the bounds word of that row, and `wr_sel` = 4 loads the configuration word. Either takes effect at the next rising clock edge. Writes with `wr_sel` = 5, 6 or 7 change nothing that the outputs show.
- R3: In a bounds word, bits 15:0 hold the end page and bits 31:16 hold the start page. Address bits 39:24 form the page, and a populated row matches when start <= page <= end. The end is inclusive for all 24 low address bits.
- R4: A row whose start page equals its end page never matches, whatever the address.
- R5: `cs_match` has at most one bit set. When several rows contain the page, the lowest-numbered one is the one set, and `row_idx` gives its number.
- R6: When no populated row contains the page, `out_of_range` is 1, `cs_match` is 0 and `row_idx` is 0. Otherwise `out_of_range` is 0.
- R7: Configuration bits 31:24 give `mem_type` as follows: 0x02 gives 1, 0x03 gives 2, 0x07 gives 3, 0x05 gives 4, and any other value gives 0 (unknown).
- R8: `registered` equals configuration bit 16, whatever the type field holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target: 0..3 row bounds, 4 configuration |
| wr_data | input | 32 | Write data |
| phys_addr | input | 40 | Physical address to decode |
| cs_match | output | 4 | One-hot row select |
| row_idx | output | 2 | Index of the selected row |
| out_of_range | output | 1 | No populated row holds the address |
| mem_type | output | 3 | Decoded memory generation, 0 meaning unknown |
| registered | output | 1 | Registered-module flag |

## Verification
The hardest case to reach from the ports is a page claimed by several rows at once while another row is empty yet names a page inside that span. Only this case shows whether priority and the empty-row rule are applied together. The stimulus programs deliberately overlapping and degenerate bounds words. It then sweeps every page of the window with both the lowest and the highest byte address of each page, so that both inclusive edges of every row are exercised. A final set of bounds sits at the top of the 40-bit space so that the widest page values are compared.

// File: rtl/cs_range_decoder.sv
module cs_range_decoder #(
  parameter int NUM_ROWS   = 4,
  parameter int ADDR_W     = 40,
  parameter int UNIT_SHIFT = 24
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [$clog2(NUM_ROWS+1)-1:0] wr_sel,
  input  logic [31:0]                   wr_data,
  input  logic [ADDR_W-1:0]             phys_addr,
  output logic [NUM_ROWS-1:0]           cs_match,
  output logic [$clog2(NUM_ROWS)-1:0]   row_idx,
  output logic                          out_of_range,
  output logic [2:0]                    mem_type,
  output logic                          registered
);
  localparam int SEL_W  = $clog2(NUM_ROWS + 1);
  localparam int IDX_W  = $clog2(NUM_ROWS);
  localparam int PAGE_W = ADDR_W - UNIT_SHIFT;

  logic [31:0]         bnd_q [NUM_ROWS];
  logic [31:0]         cfg_q;
  logic [NUM_ROWS-1:0] hit;
  logic [PAGE_W-1:0]   page;
  logic [IDX_W-1:0]    win;
  logic                any;

  assign page = phys_addr[ADDR_W-1:UNIT_SHIFT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ROWS; i++) bnd_q[i] <= '0;
      cfg_q <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_ROWS; i++)
        if (wr_sel == SEL_W'(i)) bnd_q[i] <= wr_data;
      if (wr_sel == SEL_W'(NUM_ROWS)) cfg_q <= wr_data;
    end
  end

  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row
    logic [PAGE_W-1:0] lo, hi;
    assign lo = PAGE_W'(bnd_q[g][31:16]);
    assign hi = PAGE_W'(bnd_q[g][15:0]);
    assign hit[g] = (lo != hi) && (page >= lo) && (page <= hi);
  end

  always_comb begin
    win = '0;
    any = 1'b0;
    for (int i = NUM_ROWS - 1; i >= 0; i--)
      if (hit[i]) begin
        win = IDX_W'(i);
        any = 1'b1;
      end
  end

  assign cs_match     = any ? (NUM_ROWS'(1) << win) : '0;
  assign row_idx      = win;
  assign out_of_range = !any;

  always_comb begin
    case (cfg_q[31:24])
      8'h02:   mem_type = 3'd1;
      8'h03:   mem_type = 3'd2;
      8'h07:   mem_type = 3'd3;
      8'h05:   mem_type = 3'd4;
      default: mem_type = 3'd0;
    endcase
  end

  assign registered = cfg_q[16];
endmodule

module cs_range_decoder_chk #(
  parameter int NUM_ROWS = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          wr_en,
  input logic [$clog2(NUM_ROWS+1)-1:0] wr_sel,
  input logic [31:0]                   wr_data,
  input logic [NUM_ROWS-1:0]           cs_match,
  input logic [$clog2(NUM_ROWS)-1:0]   row_idx,
  input logic                          out_of_range,
  input logic [2:0]                    mem_type,
  input logic [31:0]                   bnd [NUM_ROWS],
  input logic [31:0]                   cfg
);
  localparam int SEL_W = $clog2(NUM_ROWS + 1);

  a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_match));

  a_r5_idx_points: assert property (@(posedge clk) disable iff (!rst_n)
    !out_of_range |-> cs_match[row_idx]);

  a_r6_none: assert property (@(posedge clk) disable iff (!rst_n)
    out_of_range |-> (cs_match == '0) && (row_idx == '0));

  a_r2_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_W'(NUM_ROWS)) |=> cfg == $past(wr_data));

  a_r7_ddr3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[31:24] == 8'h07) |-> mem_type == 3'd3);

  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_chk
    a_r4_empty_row: assert property (@(posedge clk) disable iff (!rst_n)
      (bnd[g][31:16] == bnd[g][15:0]) |-> !cs_match[g]);

    a_r2_row_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_W'(g)) |=> bnd[g] == $past(wr_data));
  end
endmodule

bind cs_range_decoder cs_range_decoder_chk #(.NUM_ROWS(NUM_ROWS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .cs_match(cs_match), .row_idx(row_idx), .out_of_range(out_of_range),
  .mem_type(mem_type), .bnd(bnd_q), .cfg(cfg_q)
);

// File: tb/cs_range_decoder_bench.sv
module cs_range_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [39:0] phys_addr = '0;
  logic [3:0]  cs_match;
  logic [1:0]  row_idx;
  logic        out_of_range;
  logic [2:0]  mem_type;
  logic        registered;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] mdl_bnd [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  cs_range_decoder u_cs_range_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .phys_addr(phys_addr), .cs_match(cs_match), .row_idx(row_idx),
    .out_of_range(out_of_range), .mem_type(mem_type), .registered(registered)
  );

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (sel < 3'd4) mdl_bnd[sel] = d;
  endtask

  task automatic probe(input string tag, input logic [39:0] a);
    logic [15:0] pg;
    logic [3:0]  em;
    logic [1:0]  ei;
    logic        eo;
    pg = a[39:24];
    em = '0; ei = '0; eo = 1'b1;
    for (int r = 3; r >= 0; r--)
      if (mdl_bnd[r][31:16] != mdl_bnd[r][15:0] &&
          pg >= mdl_bnd[r][31:16] && pg <= mdl_bnd[r][15:0]) begin
        em = 4'(1 << r); ei = 2'(r); eo = 1'b0;
      end
    phys_addr = a;
    #1;
    cmp({tag, " cs_match"}, 32'(cs_match), 32'(em));
    cmp({tag, " row_idx"}, 32'(row_idx), 32'(ei));
    cmp({tag, " out_of_range"}, 32'(out_of_range), 32'(eo));
  endtask

  task automatic sweep(input string tag, input int last_pg);
    for (int p = 0; p <= last_pg; p++) begin
      probe(tag, {16'(p), 24'h000000});
      probe(tag, {16'(p), 24'hFFFFFF});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 4; r++) mdl_bnd[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    probe("R1 reset", 40'h00_0000_0000);
    probe("R1 reset", 40'hFF_FFFF_FFFF);
    cmp("R1 mem_type", 32'(mem_type), 0);
    cmp("R1 registered", 32'(registered), 0);

    // R3 R4 R6: disjoint rows, one empty row naming page 0x10
    wr(3'd0, 32'h0000_0003);
    wr(3'd1, 32'h0004_0007);
    wr(3'd2, 32'h0010_0010);
    wr(3'd3, 32'h0008_000F);
    sweep("R3_R4_R6 disjoint", 31);

    // R5: overlapping rows, lowest index wins; R4 empty row inside span
    wr(3'd0, 32'h0005_0009);
    wr(3'd1, 32'h0000_0014);
    wr(3'd2, 32'h0008_001E);
    wr(3'd3, 32'h0002_0002);
    sweep("R5 overlap", 40);

    // R2: unused selects must leave the decode unchanged
    wr(3'd5, 32'h0000_FFFF);
    wr(3'd6, 32'h0000_FFFF);
    wr(3'd7, 32'h0000_FFFF);
    sweep("R2 unused_sel", 40);
    cmp("R2 unused_sel mem_type", 32'(mem_type), 0);

    // R3: top of the address space, inclusive end
    wr(3'd0, 32'h0000_0000);
    wr(3'd1, 32'h0000_0000);
    wr(3'd2, 32'h0000_0000);
    wr(3'd3, 32'hFFF0_FFFF);
    probe("R3 top", 40'hFF_FFFF_FFFF);
    probe("R3 top", 40'hFF_F000_0000);
    probe("R3 top", 40'hFF_EFFF_FFFF);
    probe("R3 top", 40'h00_0000_0000);

    // R7 R8: every type byte with the registered bit clear and set
    for (int t = 0; t < 256; t++)
      for (int rb = 0; rb < 2; rb++) begin
        logic [2:0] et;
        wr(3'd4, {8'(t), 7'h55, 1'(rb), 16'hA5A5});
        #1;
        case (t)
          8'h02: et = 3'd1;
          8'h03: et = 3'd2;
          8'h07: et = 3'd3;
          8'h05: et = 3'd4;
          default: et = 3'd0;
        endcase
        cmp("R7 mem_type", 32'(mem_type), 32'(et));
        cmp("R8 registered", 32'(registered), 32'(rb));
      end

    // R2: configuration writes did not touch row bounds
    probe("R2 cfg_no_row_effect", 40'hFF_F800_0000);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule